// File: doc/BRIEF.md
# Linked-List Sharer Directory

This block keeps coherence sharer information for a set of cache lines without a sharer bit vector. Each line's home entry holds one head pointer naming a single caching node, and the rest of the sharers hang off it as a doubly linked list. The forward and backward links would live beside the line in each cache. Here they are held in a node-by-line link table inside the block. An all-ones node id is the null pointer. It marks both an empty list and the end of a list.

Three kinds of request arrive one at a time. A read miss puts the requester at the front of the line's list. An eviction splices a node out by joining its two neighbours, and moves the head pointer when the node was first. A write miss walks the list from the head. It raises one invalidation request for each other sharer and waits for that sharer's acknowledgement before it moves to the next one, so its latency grows with the number of sharers. After the walk the writer is left as the only member. Each finished request gives a one-cycle done pulse. Nothing here carries line data or models the network.

Top module: `ll_sharer_dir`

## Requirements
- R1: After reset, `req_ready` is 1 while `inv_valid` and `op_done` are 0, and every line's list is empty. A write to any line then completes with no invalidation.
- R2: Request codes on `req_op` are 2'b00 read miss, 2'b01 write miss, 2'b10 eviction and 2'b11 no operation. A read miss by a node that is not yet in the list places it at the head, in front of the previous head.
- R3: A read miss by a node that is already in the line's list leaves the list order unchanged.
- R4: A write miss raises invalidations in list order, starting at the head. The writer is skipped, and every other member is targeted exactly once with `inv_line` set to the written line.
- R5: An invalidation request keeps `inv_valid` high and `inv_node` stable until `inv_ack` is sampled high. An `inv_ack` seen while `inv_valid` is low has no effect.
- R6: After a write miss completes, the line's list holds only the writer.
- R7: An eviction removes the node wherever it sits (head, middle or tail) and the remaining order is kept. Removing the head makes its successor the new head.
- R8: Evicting a node that is not in the line's list changes nothing. A no-operation code changes nothing either, and both still complete with `op_done`.
- R9: `op_done` is high for exactly one cycle per accepted request. For a read, eviction or no-op it rises in the cycle after acceptance. While a write walk runs, `req_ready` is 0 and requests are ignored. A request naming a node id of `NODES` or more is dropped, and no done pulse follows it.
- R10: Lists of different lines are independent. A write to one line raises no invalidation for another line's sharers.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Request present; accepted when `req_ready` is 1 |
| req_op | input | 2 | 00 read miss, 01 write miss, 10 eviction, 11 no-op |
| req_node | input | NW | Requesting node id |
| req_line | input | LW | Line index |
| req_ready | output | 1 | Block idle and able to take a request |
| inv_valid | output | 1 | Invalidation request outstanding |
| inv_node | output | NW | Target node of the invalidation |
| inv_line | output | LW | Line being invalidated |
| inv_ack | input | 1 | Target acknowledges the current invalidation |
| op_done | output | 1 | One-cycle pulse when a request completes |

## Verification
Two things can happen in the same cycle during a walk: an acknowledgement retires the current sharer, and the next sharer's invalidation is raised. The bench provokes this by acknowledging at once, so `inv_ack` stays high across consecutive targets. The scoreboard then confirms that each expected sharer appears exactly once and in list order, with none merged and none repeated. The bench also sends a stray acknowledgement while the block is idle, and a read and an eviction while a slow walk is under way. A later write to the same line then lays the list bare, which shows that neither the stray acknowledgement nor the ignored requests changed it.

// File: rtl/ll_dir_pkg.sv
package ll_dir_pkg;

   typedef enum logic [1:0] {
      OP_READ  = 2'b00,
      OP_WRITE = 2'b01,
      OP_EVICT = 2'b10,
      OP_NONE  = 2'b11
   } dir_op_e;

   typedef enum logic {
      ST_IDLE = 1'b0,
      ST_WALK = 1'b1
   } walk_st_e;

endpackage

// File: rtl/ll_dir_head_tbl.sv
module ll_dir_head_tbl #(
   parameter int NODES = 4,
   parameter int LINES = 8,
   parameter int NW    = 3,
   parameter int LW    = 3
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic [LW-1:0] rd_line,
   output logic [NW-1:0] rd_head,
   input  logic          wr_en,
   input  logic [LW-1:0] wr_line,
   input  logic [NW-1:0] wr_val
);
   localparam logic [NW-1:0] NUL = '1;

   logic [NW-1:0] head_q [LINES];

   for (genvar l = 0; l < LINES; l++) begin : g_line
      always_ff @(posedge clk) begin
         if (!rst_n) begin
            head_q[l] <= NUL;
         end else if (wr_en && (int'(wr_line) == l)) begin
            head_q[l] <= wr_val;
         end
      end

      // R2: a head pointer is always null or names a real node
      a_r2_head_range: assert property (@(posedge clk) disable iff (!rst_n)
         (head_q[l] == NUL) || (int'(head_q[l]) < NODES));
   end

   always_comb begin
      rd_head = NUL;
      if (int'(rd_line) < LINES) rd_head = head_q[rd_line];
   end

endmodule

// File: rtl/ll_dir_link_tbl.sv
module ll_dir_link_tbl #(
   parameter int NODES = 4,
   parameter int LINES = 8,
   parameter int NW    = 3,
   parameter int LW    = 3
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic [LW-1:0] line,
   // read port a: full entry
   input  logic [NW-1:0] rda_node,
   output logic          rda_valid,
   output logic [NW-1:0] rda_prev,
   output logic [NW-1:0] rda_next,
   // read port b: forward link only
   input  logic [NW-1:0] rdb_node,
   output logic [NW-1:0] rdb_next,
   // whole-entry write: valid, prev null
   input  logic          ent_en,
   input  logic [NW-1:0] ent_node,
   input  logic [NW-1:0] ent_next,
   // entry clear
   input  logic          clr_en,
   input  logic [NW-1:0] clr_node,
   // forward-link write
   input  logic          nx_en,
   input  logic [NW-1:0] nx_node,
   input  logic [NW-1:0] nx_val,
   // backward-link write
   input  logic          pv_en,
   input  logic [NW-1:0] pv_node,
   input  logic [NW-1:0] pv_val
);
   localparam int ENT = NODES * LINES;
   localparam logic [NW-1:0] NUL = '1;

   logic          vld_q [ENT];
   logic [NW-1:0] prv_q [ENT];
   logic [NW-1:0] nxt_q [ENT];

   for (genvar n = 0; n < NODES; n++) begin : g_node
      for (genvar l = 0; l < LINES; l++) begin : g_line
         localparam int IDX = n * LINES + l;
         logic here;
         assign here = (int'(line) == l);

         always_ff @(posedge clk) begin
            if (!rst_n) begin
               vld_q[IDX] <= 1'b0;
               prv_q[IDX] <= NUL;
               nxt_q[IDX] <= NUL;
            end else if (here) begin
               if (ent_en && (int'(ent_node) == n)) begin
                  vld_q[IDX] <= 1'b1;
                  prv_q[IDX] <= NUL;
                  nxt_q[IDX] <= ent_next;
               end else if (clr_en && (int'(clr_node) == n)) begin
                  vld_q[IDX] <= 1'b0;
                  prv_q[IDX] <= NUL;
                  nxt_q[IDX] <= NUL;
               end else begin
                  if (nx_en && (int'(nx_node) == n)) nxt_q[IDX] <= nx_val;
                  if (pv_en && (int'(pv_node) == n)) prv_q[IDX] <= pv_val;
               end
            end
         end

         // R7: relinking never leaves a member pointing at itself
         a_r7_no_self_link: assert property (@(posedge clk) disable iff (!rst_n)
            vld_q[IDX] |-> ((int'(nxt_q[IDX]) != n) && (int'(prv_q[IDX]) != n)));
      end
   end

   int idx_a;
   int idx_b;

   always_comb begin
      idx_a     = 0;
      rda_valid = 1'b0;
      rda_prev  = NUL;
      rda_next  = NUL;
      if ((int'(rda_node) < NODES) && (int'(line) < LINES)) begin
         idx_a     = int'(rda_node) * LINES + int'(line);
         rda_valid = vld_q[idx_a];
         rda_prev  = prv_q[idx_a];
         rda_next  = nxt_q[idx_a];
      end
   end

   always_comb begin
      idx_b    = 0;
      rdb_next = NUL;
      if ((int'(rdb_node) < NODES) && (int'(line) < LINES)) begin
         idx_b    = int'(rdb_node) * LINES + int'(line);
         rdb_next = nxt_q[idx_b];
      end
   end

endmodule

// File: rtl/ll_dir_ctrl.sv
module ll_dir_ctrl
   import ll_dir_pkg::*;
#(
   parameter int NODES = 4,
   parameter int LINES = 8,
   parameter int NW    = 3,
   parameter int LW    = 3
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          req_valid,
   input  logic [1:0]    req_op,
   input  logic [NW-1:0] req_node,
   input  logic [LW-1:0] req_line,
   output logic          ready,
   output logic          inv_valid,
   output logic [NW-1:0] inv_node,
   output logic [LW-1:0] inv_line,
   input  logic          inv_ack,
   output logic          done,
   // table side
   output logic [LW-1:0] act_line,
   input  logic [NW-1:0] head_rd,
   output logic          head_we,
   output logic [NW-1:0] head_wv,
   input  logic          a_valid,
   input  logic [NW-1:0] a_prev,
   input  logic [NW-1:0] a_next,
   output logic [NW-1:0] walk_node,
   input  logic [NW-1:0] b_next,
   output logic          ent_en,
   output logic [NW-1:0] ent_node,
   output logic [NW-1:0] ent_next,
   output logic          clr_en,
   output logic [NW-1:0] clr_node,
   output logic          nx_en,
   output logic [NW-1:0] nx_node,
   output logic [NW-1:0] nx_val,
   output logic          pv_en,
   output logic [NW-1:0] pv_node,
   output logic [NW-1:0] pv_val
);
   localparam logic [NW-1:0] NUL = '1;

   walk_st_e      state_q;
   logic [NW-1:0] wr_q;
   logic [NW-1:0] cur_q;
   logic [LW-1:0] line_q;
   logic          done_q;
   logic          accept;
   dir_op_e       op;

   assign op        = dir_op_e'(req_op);
   assign ready     = (state_q == ST_IDLE);
   assign accept    = ready && req_valid && (int'(req_node) < NODES) && (int'(req_line) < LINES);
   assign act_line  = ready ? req_line : line_q;
   assign walk_node = cur_q;
   assign inv_node  = cur_q;
   assign inv_line  = line_q;
   assign done      = done_q;

   always_comb begin
      inv_valid = 1'b0;
      ent_en    = 1'b0;
      ent_node  = req_node;
      ent_next  = NUL;
      clr_en    = 1'b0;
      clr_node  = req_node;
      nx_en     = 1'b0;
      nx_node   = a_prev;
      nx_val    = a_next;
      pv_en     = 1'b0;
      pv_node   = a_next;
      pv_val    = a_prev;
      head_we   = 1'b0;
      head_wv   = NUL;
      if (accept) begin
         unique case (op)
            OP_READ: begin
               if (!a_valid) begin
                  ent_en   = 1'b1;
                  ent_next = head_rd;
                  head_we  = 1'b1;
                  head_wv  = req_node;
                  if (head_rd != NUL) begin
                     pv_en   = 1'b1;
                     pv_node = head_rd;
                     pv_val  = req_node;
                  end
               end
            end
            OP_EVICT: begin
               if (a_valid) begin
                  clr_en = 1'b1;
                  if (a_prev == NUL) begin
                     head_we = 1'b1;
                     head_wv = a_next;
                  end else begin
                     nx_en = 1'b1;
                  end
                  if (a_next != NUL) pv_en = 1'b1;
               end
            end
            default: ;
         endcase
      end else if (!ready) begin
         if (cur_q == NUL) begin
            ent_en   = 1'b1;
            ent_node = wr_q;
            head_we  = 1'b1;
            head_wv  = wr_q;
         end else if (cur_q != wr_q) begin
            inv_valid = 1'b1;
            if (inv_ack) begin
               clr_en   = 1'b1;
               clr_node = cur_q;
            end
         end
      end
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         state_q <= ST_IDLE;
         wr_q    <= NUL;
         cur_q   <= NUL;
         line_q  <= '0;
         done_q  <= 1'b0;
      end else begin
         done_q <= 1'b0;
         if (accept) begin
            if (op == OP_WRITE) begin
               state_q <= ST_WALK;
               wr_q    <= req_node;
               line_q  <= req_line;
               cur_q   <= head_rd;
            end else begin
               done_q <= 1'b1;
            end
         end else if (state_q == ST_WALK) begin
            if (cur_q == NUL) begin
               state_q <= ST_IDLE;
               done_q  <= 1'b1;
            end else if ((cur_q == wr_q) || inv_ack) begin
               cur_q <= b_next;
            end
         end
      end
   end

   // R5: an unacknowledged invalidation holds its target
   a_r5_inv_hold: assert property (@(posedge clk) disable iff (!rst_n)
      (inv_valid && !inv_ack) |=> (inv_valid && $stable(inv_node)));

   // R4: invalidations target real nodes other than the writer
   a_r4_inv_target: assert property (@(posedge clk) disable iff (!rst_n)
      inv_valid |-> ((int'(inv_node) < NODES) && (inv_node != wr_q)));

   // R9: invalidations only while busy
   a_r9_inv_busy: assert property (@(posedge clk) disable iff (!rst_n)
      inv_valid |-> !ready);

   // R9: completion is reported with the block idle again
   a_r9_done_idle: assert property (@(posedge clk) disable iff (!rst_n)
      done |-> ready);

   // R9: no request is taken while a walk runs
   a_r9_walk_stays: assert property (@(posedge clk) disable iff (!rst_n)
      (!ready && (cur_q != NUL)) |=> !ready);

endmodule

// File: rtl/ll_sharer_dir.sv
module ll_sharer_dir #(
   parameter  int NODES = 4,
   parameter  int LINES = 8,
   localparam int NW    = $clog2(NODES) + 1,
   localparam int LW    = (LINES > 1) ? $clog2(LINES) : 1
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          req_valid,
   input  logic [1:0]    req_op,
   input  logic [NW-1:0] req_node,
   input  logic [LW-1:0] req_line,
   output logic          req_ready,
   output logic          inv_valid,
   output logic [NW-1:0] inv_node,
   output logic [LW-1:0] inv_line,
   input  logic          inv_ack,
   output logic          op_done
);
   if (NODES < 2) begin : g_bad_nodes
      $error("ll_sharer_dir: NODES must be at least 2");
   end
   if (LINES < 1) begin : g_bad_lines
      $error("ll_sharer_dir: LINES must be at least 1");
   end

   logic [LW-1:0] act_line;
   logic [NW-1:0] head_rd, head_wv;
   logic          head_we;
   logic          a_valid;
   logic [NW-1:0] a_prev, a_next;
   logic [NW-1:0] walk_node, b_next;
   logic          ent_en, clr_en, nx_en, pv_en;
   logic [NW-1:0] ent_node, ent_next, clr_node, nx_node, nx_val, pv_node, pv_val;

   ll_dir_head_tbl #(.NODES(NODES), .LINES(LINES), .NW(NW), .LW(LW)) i_head (
      .clk     (clk),
      .rst_n   (rst_n),
      .rd_line (act_line),
      .rd_head (head_rd),
      .wr_en   (head_we),
      .wr_line (act_line),
      .wr_val  (head_wv)
   );

   ll_dir_link_tbl #(.NODES(NODES), .LINES(LINES), .NW(NW), .LW(LW)) i_link (
      .clk       (clk),
      .rst_n     (rst_n),
      .line      (act_line),
      .rda_node  (req_node),
      .rda_valid (a_valid),
      .rda_prev  (a_prev),
      .rda_next  (a_next),
      .rdb_node  (walk_node),
      .rdb_next  (b_next),
      .ent_en    (ent_en),
      .ent_node  (ent_node),
      .ent_next  (ent_next),
      .clr_en    (clr_en),
      .clr_node  (clr_node),
      .nx_en     (nx_en),
      .nx_node   (nx_node),
      .nx_val    (nx_val),
      .pv_en     (pv_en),
      .pv_node   (pv_node),
      .pv_val    (pv_val)
   );

   ll_dir_ctrl #(.NODES(NODES), .LINES(LINES), .NW(NW), .LW(LW)) i_ctrl (
      .clk       (clk),
      .rst_n     (rst_n),
      .req_valid (req_valid),
      .req_op    (req_op),
      .req_node  (req_node),
      .req_line  (req_line),
      .ready     (req_ready),
      .inv_valid (inv_valid),
      .inv_node  (inv_node),
      .inv_line  (inv_line),
      .inv_ack   (inv_ack),
      .done      (op_done),
      .act_line  (act_line),
      .head_rd   (head_rd),
      .head_we   (head_we),
      .head_wv   (head_wv),
      .a_valid   (a_valid),
      .a_prev    (a_prev),
      .a_next    (a_next),
      .walk_node (walk_node),
      .b_next    (b_next),
      .ent_en    (ent_en),
      .ent_node  (ent_node),
      .ent_next  (ent_next),
      .clr_en    (clr_en),
      .clr_node  (clr_node),
      .nx_en     (nx_en),
      .nx_node   (nx_node),
      .nx_val    (nx_val),
      .pv_en     (pv_en),
      .pv_node   (pv_node),
      .pv_val    (pv_val)
   );

endmodule

// File: tb/test_ll_sharer_dir.sv
module test_ll_sharer_dir;
   localparam int CLK_PERIOD = 10;
   localparam int NODES = 4;
   localparam int LINES = 8;
   localparam int NW = $clog2(NODES) + 1;
   localparam int LW = $clog2(LINES);

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic          req_valid = 1'b0;
   logic [1:0]    req_op = 2'b00;
   logic [NW-1:0] req_node = '0;
   logic [LW-1:0] req_line = '0;
   logic          req_ready, inv_valid, op_done, inv_ack;
   logic [NW-1:0] inv_node;
   logic [LW-1:0] inv_line;
   logic          resp_ack = 1'b0;
   logic          stray_ack = 1'b0;

   assign inv_ack = resp_ack | stray_ack;

   always #(CLK_PERIOD/2) clk = ~clk;

   ll_sharer_dir #(.NODES(NODES), .LINES(LINES)) i_ll_sharer_dir (
      .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_op(req_op),
      .req_node(req_node), .req_line(req_line), .req_ready(req_ready),
      .inv_valid(inv_valid), .inv_node(inv_node), .inv_line(inv_line),
      .inv_ack(inv_ack), .op_done(op_done)
   );

   int checks = 0;
   int errors = 0;
   int ack_delay = 0;
   int model [LINES][$];
   int exp_q [$];
   bit finished = 0;

   task automatic chk(input bit ok, input string req, input int act, input int exp);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
      end
   endtask

   // monitor and acknowledgement responder
   bit logged = 0;
   int cnt = 0;
   int held = 0;
   always @(negedge clk) begin
      if (resp_ack) begin
         resp_ack = 1'b0;
         logged = 0;
      end
      if (rst_n && inv_valid) begin
         if (!logged) begin
            int got;
            got = int'(inv_node) * 16 + int'(inv_line);
            if (exp_q.size() == 0) begin
               chk(1'b0, "R4 unexpected invalidation", got, -1);
            end else begin
               int e;
               e = exp_q.pop_front();
               chk(got == e, "R4 invalidation order (node*16+line)", got, e);
            end
            logged = 1;
            held = int'(inv_node);
            cnt = ack_delay;
         end else begin
            chk(int'(inv_node) == held, "R5 target held until ack", int'(inv_node), held);
         end
         if (cnt == 0) resp_ack = 1'b1;
         else cnt--;
      end
   end

   task automatic model_op(input int op, input int node, input int line);
      int pos;
      pos = -1;
      foreach (model[line][i]) if (model[line][i] == node) pos = i;
      case (op)
         0: if (pos < 0) model[line].push_front(node);
         1: begin
            foreach (model[line][i]) if (model[line][i] != node) exp_q.push_back(model[line][i] * 16 + line);
            model[line].delete();
            model[line].push_back(node);
         end
         2: if (pos >= 0) model[line].delete(pos);
         default: ;
      endcase
   endtask

   task automatic drive(input int op, input int node, input int line);
      while (!req_ready) @(negedge clk);
      req_valid = 1'b1;
      req_op    = 2'(op);
      req_node  = NW'(node);
      req_line  = LW'(line);
      @(negedge clk);
      req_valid = 1'b0;
   endtask

   task automatic wait_done(input string req);
      int t;
      t = 0;
      while (!op_done && t < 400) begin
         @(negedge clk);
         t++;
      end
      chk(op_done == 1'b1, req, int'(op_done), 1);
      @(negedge clk);
      chk(op_done == 1'b0, "R9 done lasts one cycle", int'(op_done), 0);
   endtask

   task automatic do_op(input int op, input int node, input int line, input int dly, input string req);
      ack_delay = dly;
      model_op(op, node, line);
      drive(op, node, line);
      if (op != 1) chk(op_done == 1'b1, "R9 done one cycle after accept", int'(op_done), 1);
      wait_done(req);
      if (op == 1) chk(exp_q.size() == 0, "R4 all sharers invalidated before done", exp_q.size(), 0);
   endtask

   initial begin
      repeat (150000) @(posedge clk);
      if (!finished) begin
         errors++;
         $display("FAIL watchdog expired actual=running expected=finished");
         $display("CHECKS %0d ERRORS %0d", checks, errors);
         $finish;
      end
   end

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      // R1 reset state
      chk(req_ready == 1'b1, "R1 ready after reset", int'(req_ready), 1);
      chk(inv_valid == 1'b0, "R1 no invalidation after reset", int'(inv_valid), 0);
      chk(op_done == 1'b0, "R1 no done after reset", int'(op_done), 0);
      do_op(1, 0, 0, 0, "R1 write on empty line");

      // R2 R3 R4 R6: insertion order revealed by a slow walk
      do_op(0, 0, 1, 0, "R2 read n0");
      do_op(0, 1, 1, 0, "R2 read n1");
      do_op(0, 2, 1, 0, "R2 read n2");
      do_op(0, 1, 1, 0, "R3 repeated read");
      do_op(1, 3, 1, 2, "R4 write walk");
      do_op(1, 0, 1, 1, "R6 writer sole member");

      // R7 R8 evictions
      for (int n = 0; n < 4; n++) do_op(0, n, 2, 0, "R2 fill line2");
      do_op(2, 1, 2, 0, "R7 evict middle");
      do_op(2, 3, 2, 0, "R7 evict head");
      do_op(2, 0, 2, 0, "R7 evict tail");
      do_op(2, 1, 2, 0, "R8 evict non-member");
      do_op(3, 0, 2, 0, "R8 no-op");
      do_op(0, 1, 2, 0, "R2 read after evictions");
      do_op(1, 2, 2, 0, "R4 write by tail member");
      do_op(1, 2, 2, 0, "R6 write by sole member");

      // R10 independent lines
      do_op(0, 0, 3, 0, "R10 read line3");
      do_op(0, 1, 4, 0, "R10 read line4");
      do_op(1, 2, 3, 0, "R10 write line3");
      do_op(1, 3, 4, 0, "R10 write line4");

      // R5 stray ack while idle, then immediate acks back to back
      do_op(0, 0, 5, 0, "R2 read line5 n0");
      do_op(0, 1, 5, 0, "R2 read line5 n1");
      stray_ack = 1'b1;
      repeat (3) @(negedge clk);
      stray_ack = 1'b0;
      do_op(0, 3, 5, 0, "R2 read line5 n3");
      do_op(1, 2, 5, 0, "R5 stray ack ignored");

      // R9 requests during a walk are ignored
      do_op(0, 0, 6, 0, "R2 read line6 n0");
      do_op(0, 1, 6, 0, "R2 read line6 n1");
      ack_delay = 4;
      model_op(1, 3, 6);
      drive(1, 3, 6);
      chk(req_ready == 1'b0, "R9 busy during walk", int'(req_ready), 0);
      req_valid = 1'b1; req_op = 2'b00; req_node = NW'(2); req_line = LW'(6);
      @(negedge clk);
      req_op = 2'b10; req_node = NW'(0);
      @(negedge clk);
      req_valid = 1'b0;
      wait_done("R9 walk completes");
      do_op(1, 1, 6, 0, "R9 busy requests left list intact");

      // R9 out-of-range node dropped
      req_valid = 1'b1; req_op = 2'b00; req_node = NW'(5); req_line = LW'(7);
      @(negedge clk);
      req_valid = 1'b0;
      begin
         bit seen;
         seen = 0;
         repeat (5) begin
            if (op_done) seen = 1;
            @(negedge clk);
         end
         chk(!seen, "R9 bad node gives no done", int'(seen), 0);
      end
      do_op(0, 0, 7, 0, "R2 read line7");
      do_op(2, 0, 7, 0, "R7 evict only member");
      do_op(1, 1, 7, 0, "R7 emptied list and bad node left no sharer");

      repeat (3) @(negedge clk);
      chk(exp_q.size() == 0, "R4 scoreboard drained", exp_q.size(), 0);
      finished = 1;
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end

endmodule